// File: doc/BRIEF.md
# Multicore private region decoder

This block sits on a single-master register bus and owns an 8 KB window of private peripherals for one processor cluster. It decodes the 13-bit offset of each request. A small snoop-control register bank is held inside the block. All other accesses go out to one of several downstream register ports: the per-core interrupt CPU interfaces, the per-core timers, the per-core watchdogs and the shared interrupt distributor. Windows in the address map that have no target return an error and are never forwarded.

Each per-core group of ports has one extra copy at its low end. This copy is an alias that stands for "the core making the request". An access to the alias leaves the block with the requester's core id on the core sideband. An access to an explicit per-core window carries that window's own core number. The block also maps each core's timer and watchdog interrupt lines to fixed bit positions in that core's private interrupt bank.

A request is held stable on the upstream bus until `resp_valid` pulses for one cycle. The master may present the next request in the cycle after that pulse. The core count `NCORE` is a parameter from 1 to 4.

Top module: `mpriv_decoder`

## Requirements
- R1: The control register at offset 0x00 resets to 0. A write stores only bit 0 of the write data. A read returns that bit in bit 0, with every other bit zero.
- R2: Offset 0x04 reads as (NCORE-1) in bits [1:0] and as a run of NCORE ones starting at bit 4. For NCORE=4 this is 0xF3. Writes to offset 0x04 have no effect.
- R3: Offsets 0x08 and 0x0C read as zero. Writes to either offset leave the control register unchanged.
- R4: Inside 0x000–0x0FF, every offset other than 0x00, 0x04, 0x08 and 0x0C reads zero and ignores writes. Such an access raises `scu_bad_log` in the same cycle as its `resp_valid`, with `resp_err` low. The four defined offsets never raise `scu_bad_log`.
- R5: Offset 0x100+k*0x100, for k = 0..NCORE, forwards to port index k with `dn_addr` = offset[7:0]. `dn_core` is `req_core` when k = 0 and k-1 otherwise.
- R6: Take page p = 6..6+NCORE, with k = p-6. Offsets 0x00–0x1F within the page forward to timer port NCORE+1+k. Offsets 0x20–0x3F forward to watchdog port 2*NCORE+2+k. In both cases `dn_addr` = offset[4:0], and `dn_core` follows the same rule as in R5.
- R7: Offsets 0x1000–0x1FFF forward to the distributor port, index 3*NCORE+3, with `dn_addr` = offset[11:0] and `dn_core` = `req_core`.
- R8: Any other offset returns `resp_err`=1 with `resp_rdata`=0, and no `dn_valid` bit rises.
- R9: A local or unmapped access responds one cycle after the request is presented. A forwarded access holds `dn_valid` until `dn_ready` and responds one cycle after the ready cycle. The response carries that port's `dn_rdata`, and `dn_write`/`dn_wdata` pass through unchanged.
- R10: `priv_irq` bit c*32+29 follows `tmr_irq[c]` and bit c*32+30 follows `wdg_irq[c]`. All other bits are zero.
- R11: At most one `dn_valid` bit is high at a time, and none is high while `resp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present; held until response |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Offset within the window |
| req_wdata | input | 32 | Write data |
| req_core | input | 2 | Id of the requesting core |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_rdata | output | 32 | Read data |
| resp_err | output | 1 | Unmapped offset |
| scu_bad_log | output | 1 | Pulse for an undefined snoop-control offset |
| dn_valid | output | 3*NCORE+4 | Per-port request valid |
| dn_ready | input | 3*NCORE+4 | Per-port ready |
| dn_write | output | 1 | Forwarded write flag |
| dn_addr | output | 12 | Offset within the selected window |
| dn_wdata | output | 32 | Forwarded write data |
| dn_core | output | 2 | Core sideband |
| dn_rdata | input | 32*(3*NCORE+4) | Per-port read data, port p at bits [p*32 +: 32] |
| tmr_irq | input | NCORE | Per-core timer interrupt |
| wdg_irq | input | NCORE | Per-core watchdog interrupt |
| priv_irq | output | 32*NCORE | Per-core private interrupt banks |

## Verification
The hardest case to produce from the ports is a forwarded access that sits waiting on a slow port. During that wait the routed port, the window-local offset and the alias core id must all hold steady, and the response must come exactly one cycle after ready. Timer pages are also hard because they contain unmapped holes just past the watchdog range. The stimulus sweeps every 256-byte page and, within each page, the sub-offsets on both sides of the 0x20 and 0x40 boundaries. For each access it varies the ready delay from zero to two cycles and rotates the requesting core id. The expected port, offset, core and latency are all computed from the address arithmetic.

// File: rtl/mpriv_pkg.sv
package mpriv_pkg;
  localparam int CORE_W = 2;
  localparam int PORT_W = 5;
  localparam int LOC_W  = 12;

  typedef enum logic [1:0] {TGT_SCU, TGT_PORT, TGT_GAP} tgt_e;
  typedef enum logic {ST_IDLE, ST_RESP} st_e;

  typedef struct packed {
    tgt_e              tgt;
    logic [PORT_W-1:0] port;
    logic [LOC_W-1:0]  loc;
    logic [CORE_W-1:0] core;
  } route_t;
endpackage

// File: rtl/mpriv_addr_dec.sv
module mpriv_addr_dec
  import mpriv_pkg::*;
#(
  parameter int NCORE = 4
) (
  input  logic [12:0]       addr,
  input  logic [CORE_W-1:0] req_core,
  output route_t            route
);
  localparam int TMR_PAGE = 6;
  localparam int DIST_IDX = 3*NCORE + 3;

  logic [3:0] page;
  logic [3:0] k;

  always_comb begin
    page  = addr[11:8];
    k     = '0;
    route = '{tgt: TGT_GAP, port: '0, loc: '0, core: req_core};
    if (addr[12]) begin
      route.tgt  = TGT_PORT;
      route.port = PORT_W'(DIST_IDX);
      route.loc  = addr[11:0];
    end else if (page == 4'd0) begin
      route.tgt = TGT_SCU;
      route.loc = LOC_W'(addr[7:0]);
    end else if (page <= 4'(NCORE + 1)) begin
      k          = page - 4'd1;
      route.tgt  = TGT_PORT;
      route.port = PORT_W'(k);
      route.loc  = LOC_W'(addr[7:0]);
    end else if (page >= 4'(TMR_PAGE) && page <= 4'(TMR_PAGE + NCORE)) begin
      k = page - 4'(TMR_PAGE);
      if (addr[7:6] == 2'b00) begin
        route.tgt  = TGT_PORT;
        route.port = addr[5] ? PORT_W'(2*NCORE + 2) + PORT_W'(k)
                             : PORT_W'(NCORE + 1) + PORT_W'(k);
        route.loc  = LOC_W'(addr[4:0]);
      end
    end
    if (k != 4'd0) route.core = CORE_W'(k - 4'd1);
  end
endmodule

// File: rtl/mpriv_scu_regs.sv
module mpriv_scu_regs #(
  parameter int NCORE = 4,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic          acc_wr,
  input  logic [7:0]    acc_off,
  input  logic          acc_wbit,
  output logic [DW-1:0] rdata,
  output logic          bad
);
  localparam logic [DW-1:0] CFG_VAL =
    DW'((((1 << NCORE) - 1) << 4) | (NCORE - 1));

  logic ctrl_q, ctrl_d, ctrl_en;

  always_comb begin
    ctrl_en = acc_en && acc_wr && (acc_off == 8'h00);
    ctrl_d  = acc_wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= 1'b0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_comb begin
    rdata = '0;
    bad   = 1'b0;
    case (acc_off)
      8'h00:        rdata = DW'(ctrl_q);
      8'h04:        rdata = CFG_VAL;
      8'h08, 8'h0C: rdata = '0;
      default:      bad   = acc_en;
    endcase
  end

  // R1: the stored bit moves only after a write to offset 0x00
  a_r1_ctrl_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(acc_en && acc_wr && acc_off == 8'h00));
  // R4: the bad-offset flag never fires for the defined offsets
  a_r4_good_offsets_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_off[7:4] == 4'h0 && acc_off[1:0] == 2'b00) |-> !bad);
endmodule

// File: rtl/mpriv_irq_steer.sv
module mpriv_irq_steer #(
  parameter int NCORE   = 4,
  parameter int BANK    = 32,
  parameter int TMR_BIT = 29,
  parameter int WDG_BIT = 30
) (
  input  logic [NCORE-1:0]      tmr_irq,
  input  logic [NCORE-1:0]      wdg_irq,
  output logic [NCORE*BANK-1:0] priv_irq
);
  for (genvar c = 0; c < NCORE; c++) begin : g_core
    always_comb begin
      priv_irq[c*BANK +: BANK]          = '0;
      priv_irq[c*BANK + TMR_BIT]        = tmr_irq[c];
      priv_irq[c*BANK + WDG_BIT]        = wdg_irq[c];
    end
  end
endmodule

// File: rtl/mpriv_decoder.sv
module mpriv_decoder
  import mpriv_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int DW    = 32,
  localparam int NPORT = 3*NCORE + 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [12:0]         req_addr,
  input  logic [DW-1:0]       req_wdata,
  input  logic [CORE_W-1:0]   req_core,
  output logic                resp_valid,
  output logic [DW-1:0]       resp_rdata,
  output logic                resp_err,
  output logic                scu_bad_log,
  output logic [NPORT-1:0]    dn_valid,
  input  logic [NPORT-1:0]    dn_ready,
  output logic                dn_write,
  output logic [LOC_W-1:0]    dn_addr,
  output logic [DW-1:0]       dn_wdata,
  output logic [CORE_W-1:0]   dn_core,
  input  logic [NPORT*DW-1:0] dn_rdata,
  input  logic [NCORE-1:0]    tmr_irq,
  input  logic [NCORE-1:0]    wdg_irq,
  output logic [NCORE*32-1:0] priv_irq
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  route_t        route;
  st_e           state_q, state_d;
  logic          take, finish, scu_acc, scu_bad, sel_ready;
  logic [DW-1:0] scu_rdata, sel_rdata;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          err_q, err_d, log_q, log_d;

  mpriv_addr_dec #(.NCORE(NCORE)) u_dec (
    .addr(req_addr), .req_core(req_core), .route(route)
  );

  assign take    = (state_q == ST_IDLE) && req_valid;
  assign scu_acc = take && (route.tgt == TGT_SCU);

  mpriv_scu_regs #(.NCORE(NCORE), .DW(DW)) u_scu (
    .clk(clk), .rst_n(rst_s), .acc_en(scu_acc), .acc_wr(req_write),
    .acc_off(route.loc[7:0]), .acc_wbit(req_wdata[0]),
    .rdata(scu_rdata), .bad(scu_bad)
  );

  mpriv_irq_steer #(.NCORE(NCORE)) u_irq (
    .tmr_irq(tmr_irq), .wdg_irq(wdg_irq), .priv_irq(priv_irq)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign dn_valid[p] = take && (route.tgt == TGT_PORT) && (route.port == PORT_W'(p));
  end

  always_comb begin
    sel_ready = 1'b0;
    sel_rdata = '0;
    for (int p = 0; p < NPORT; p++) begin
      sel_ready = sel_ready | (dn_valid[p] & dn_ready[p]);
      if (dn_valid[p]) sel_rdata = sel_rdata | dn_rdata[p*DW +: DW];
    end
  end

  assign dn_write = req_write;
  assign dn_wdata = req_wdata;
  assign dn_addr  = route.loc;
  assign dn_core  = route.core;

  // next state
  always_comb begin
    finish  = take && ((route.tgt != TGT_PORT) || sel_ready);
    state_d = (state_q == ST_IDLE && finish) ? ST_RESP : ST_IDLE;
    unique case (route.tgt)
      TGT_SCU:  rdata_d = scu_rdata;
      TGT_PORT: rdata_d = sel_rdata;
      default:  rdata_d = '0;
    endcase
    err_d = (route.tgt == TGT_GAP);
    log_d = finish && scu_bad;
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      rdata_q <= '0;
      err_q   <= 1'b0;
      log_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      log_q   <= log_d;
      if (finish) begin
        rdata_q <= rdata_d;
        err_q   <= err_d;
      end
    end
  end

  assign resp_valid  = (state_q == ST_RESP);
  assign resp_rdata  = rdata_q;
  assign resp_err    = resp_valid & err_q;
  assign scu_bad_log = log_q;

  a_r11_single_port: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(dn_valid));
  a_r11_quiet_in_resp: assert property (@(posedge clk) disable iff (!rst_s)
    resp_valid |-> (dn_valid == '0));
  a_r9_ready_to_resp: assert property (@(posedge clk) disable iff (!rst_s)
    (|(dn_valid & dn_ready)) |=> resp_valid);
  a_r9_one_cycle_resp: assert property (@(posedge clk) disable iff (!rst_s)
    resp_valid |=> !resp_valid);
  a_r8_err_zero_data: assert property (@(posedge clk) disable iff (!rst_s)
    resp_err |-> (resp_rdata == '0));
  a_r8_err_not_forwarded: assert property (@(posedge clk) disable iff (!rst_s)
    resp_err |-> ($past(dn_valid) == '0));
  a_r4_log_with_resp: assert property (@(posedge clk) disable iff (!rst_s)
    scu_bad_log |-> (resp_valid && !resp_err));
  a_r10_irq_count: assert property (@(posedge clk) disable iff (!rst_s)
    $countones(priv_irq) == $countones(tmr_irq) + $countones(wdg_irq));
endmodule

// File: tb/mpriv_decoder_bench.sv
module mpriv_decoder_bench;
  localparam int CLK_NS = 10;
  localparam int N      = 4;
  localparam int NP     = 3*N + 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [12:0]   req_addr;
  logic [31:0]   req_wdata;
  logic [1:0]    req_core;
  logic          resp_valid, resp_err, scu_bad_log;
  logic [31:0]   resp_rdata;
  logic [NP-1:0] dn_valid, dn_ready;
  logic          dn_write;
  logic [11:0]   dn_addr;
  logic [31:0]   dn_wdata;
  logic [1:0]    dn_core;
  logic [NP*32-1:0] dn_rdata;
  logic [N-1:0]  tmr_irq, wdg_irq;
  logic [N*32-1:0] priv_irq;

  int checks = 0, errors = 0;

  // observations of the last access
  int          o_port, o_lat;
  bit          o_multi, o_wr;
  logic [11:0] o_addr;
  logic [1:0]  o_core;
  logic [31:0] o_wd, o_data;
  bit          o_err, o_log;

  always #(CLK_NS/2) clk = ~clk;

  mpriv_decoder #(.NCORE(N)) u_mpriv_decoder (.*);

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [12:0] a, input logic [31:0] wd,
                        input logic [1:0] core, input int dly);
    bit got;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_core = core;
    o_port = -1; o_multi = 0; o_lat = 0; got = 0;
    while (!got && o_lat < 40) begin
      #1;
      if (|dn_valid) begin
        if ($countones(dn_valid) != 1) o_multi = 1;
        for (int p = 0; p < NP; p++) if (dn_valid[p]) o_port = p;
        o_addr = dn_addr; o_core = dn_core; o_wr = dn_write; o_wd = dn_wdata;
      end
      dn_ready = (o_lat >= dly) ? dn_valid : '0;
      @(posedge clk); #1; o_lat++;
      if (resp_valid) begin
        got = 1; o_data = resp_rdata; o_err = resp_err; o_log = scu_bad_log;
        if (dn_valid != '0) o_multi = 1;
      end else @(negedge clk);
    end
    dn_ready = '0;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [31:0] port_data(input int p, input int seq);
    return 32'hD000_0000 | (32'(p) << 16) | 32'(seq & 16'hFFFF);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] cfg;
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    req_core = '0; dn_ready = '0; dn_rdata = '0; tmr_irq = '0; wdg_irq = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(resp_valid == 0 && dn_valid == '0, "R11 reset quiet", {resp_valid, dn_valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 control register
    access(0, 13'h000, 0, 0, 0);
    chk(o_data == 0, "R1 reset value", o_data, 0);
    chk(o_lat == 1, "R9 local latency", o_lat, 1);
    access(1, 13'h000, 32'hFFFF_FFFF, 0, 0);
    access(0, 13'h000, 0, 0, 0);
    chk(o_data == 1, "R1 keeps bit0 only", o_data, 1);
    access(1, 13'h000, 32'hFFFF_FFFE, 0, 0);
    access(0, 13'h000, 0, 0, 0);
    chk(o_data == 0, "R1 clear", o_data, 0);
    access(1, 13'h000, 32'h1, 0, 0);

    // R2 configuration, computed
    cfg = ((32'(1) << N) - 1) << 4 | 32'(N - 1);
    access(1, 13'h004, 32'h0, 0, 0);
    access(0, 13'h004, 0, 0, 0);
    chk(o_data == cfg, "R2 config value", o_data, cfg);

    // R3 status / invalidate
    access(1, 13'h00C, 32'h0, 0, 0);
    access(1, 13'h008, 32'h0, 0, 0);
    access(0, 13'h000, 0, 0, 0);
    chk(o_data == 1, "R3 writes leave control", o_data, 1);

    // R4 full sweep of the snoop-control bank
    for (int off = 0; off < 256; off++) begin
      logic [31:0] ex;
      bit good;
      good = (off == 0 || off == 4 || off == 8 || off == 12);
      ex = (off == 0) ? 32'h1 : (off == 4) ? cfg : 32'h0;
      access(0, 13'(off), 0, 2'(off), 0);
      chk(o_data == ex, "R4 bank read", o_data, ex);
      chk(o_log == !good && o_err == 0 && o_port == -1, "R4 log pulse", {o_log, o_err}, {!good, 1'b0});
      if (!good) begin
        access(1, 13'(off), 32'h0, 0, 0);
      end
    end
    access(0, 13'h000, 0, 0, 0);
    chk(o_data == 1, "R4 bad writes ignored", o_data, 1);

    // R5..R9, R11 page sweep
    for (int pg = 0; pg < 32; pg++) begin
      for (int si = 0; si < 6; si++) begin
        logic [7:0]  subs [6] = '{8'h00, 8'h1C, 8'h20, 8'h3F, 8'h40, 8'hFC};
        logic [12:0] a;
        logic [1:0]  rc;
        int ep, kk, seq, dly;
        logic [11:0] el;
        logic [1:0]  ec;
        bit scu;
        a = {pg[4:0], subs[si]};
        rc = 2'((pg + si) % 4);
        dly = pg % 3;
        seq = pg*8 + si;
        for (int p = 0; p < NP; p++) dn_rdata[p*32 +: 32] = port_data(p, seq);
        ep = -1; el = '0; ec = rc; kk = 0; scu = 0;
        if (a[12]) begin ep = 3*N + 3; el = a[11:0]; end
        else if (a[11:8] == 0) scu = 1;
        else if (a[11:8] <= N + 1) begin kk = a[11:8] - 1; ep = kk; el = 12'(a[7:0]); end
        else if (a[11:8] >= 6 && a[11:8] <= 6 + N && a[7:0] < 8'h40) begin
          kk = a[11:8] - 6;
          ep = (a[7:0] < 8'h20) ? N + 1 + kk : 2*N + 2 + kk;
          el = 12'(a[4:0]);
        end
        if (kk != 0) ec = 2'(kk - 1);
        if (scu) access(0, a, 32'h0, rc, dly);
        else     access(si[0], a, {16'hBEEF, 16'(seq)}, rc, dly);
        chk(!o_multi, "R11 one port", o_multi, 0);
        chk(o_port == ep, "R5 R6 R7 port select", o_port, ep);
        if (ep >= 0) begin
          chk(o_addr == el, "R5 R6 R7 local offset", o_addr, el);
          chk(o_core == ec, "R5 R6 R7 core id", o_core, ec);
          chk(o_wr == si[0] && o_wd == {16'hBEEF, 16'(seq)}, "R9 pass through", o_wd, {16'hBEEF, 16'(seq)});
          chk(o_data == port_data(ep, seq) && o_err == 0, "R9 read data", o_data, port_data(ep, seq));
          chk(o_lat == dly + 1, "R9 forwarded latency", o_lat, dly + 1);
        end else if (!scu) begin
          chk(o_err == 1 && o_data == 0, "R8 gap error", {o_err, o_data}, {1'b1, 32'h0});
          chk(o_lat == 1, "R8 gap latency", o_lat, 1);
        end else begin
          chk(o_err == 0, "R4 bank no error", o_err, 0);
        end
      end
    end

    // R10 interrupt steering, all combinations
    for (int v = 0; v < 256; v++) begin
      logic [N*32-1:0] ex;
      @(negedge clk);
      tmr_irq = v[3:0]; wdg_irq = v[7:4];
      #1;
      ex = '0;
      for (int c = 0; c < N; c++) begin
        ex[c*32 + 29] = v[c];
        ex[c*32 + 30] = v[4 + c];
      end
      chk(priv_irq == ex, "R10 irq map", priv_irq, ex);
    end

    summary();
    $finish;
  end
endmodule